// File: doc/BRIEF.md
# Eight-Level Programmable Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt output to a CPU. The CPU sets it up and services it through a small register port with a single address bit, separate write and read strobes and an 8-bit data bus. After a reset the controller takes no requests. It starts to take them once the CPU has written a short setup sequence: a setup word at address 0, then one or two further words at address 1. After that, address-1 writes load the mask. Address-0 writes carry either end-of-service commands or read-selection commands.

Priority is circular. A 3-bit register names the lowest-priority level, and the level just above it (modulo 8) ranks highest. Each accepted request sets its bit in the in-service register. The CPU interrupt line rises only when that level outranks everything already in service. End-of-service commands clear in-service bits and can rotate the priority. Setup choices the block does not implement are not silently accepted: cascading, automatic end of service, buffered operation, special nesting and special masking all raise a sticky error flag instead.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, address-1 writes are refused and the mask reads back 0x00. Address-0 reads return the raw request lines. `cpu_int` and `cfg_err` are low. `autovec` is 1, `cpu_level` is 1 and `vector` is 0x00.
- R2: An address-0 write with bit 4 set is a setup word. It clears `cfg_err`, sets the lowest-priority level to 7, selects the request lines for address-0 reads, disarms poll and moves to "expect word 2". Its bit 1 (single mode) and bit 0 (word 4 needed) are kept for the rest of the sequence.
- R3: An address-1 write before any setup word sets `cfg_err` and does not change the mask.
- R4: In "expect word 2", an address-1 write moves to "expect word 4" if word 4 is needed, and otherwise to ready. If single mode was not set, the write instead sets `cfg_err` and returns to the uninitialized state.
- R5: In "expect word 4", a word with bit 1, bit 3 or bit 4 set sets `cfg_err` and the sequencer keeps waiting. Any other word moves to ready. In ready, address-1 writes load the mask, and address-1 reads return it.
- R6: An address-0 write with bit 4 clear and bit 3 set is a read-control word. Bit 6 set sets `cfg_err`. Otherwise bit 2 arms poll. Otherwise bit 1 selects the read source for address 0: in-service register if bit 0 is 1, raw request lines if bit 0 is 0.
- R7: An address-0 write with bits 4 and 3 clear is a command, coded in bits 7:5. 011 clears the in-service bit named by bits 2:0. 111 does the same and also makes that level the lowest priority. 110 loads the lowest-priority level from bits 2:0. 010 does nothing. 000 and 100 set `cfg_err`.
- R8: Code 001 clears the highest-priority in-service bit. The search order is lowest+1, lowest+2, and so on modulo 8. Code 101 does the same and also makes the cleared level the lowest priority.
- R9: While poll is armed, an address-0 read returns 0x80 OR the highest-priority in-service level. If nothing is in service it returns 0x00, and the read disarms poll.
- R10: A request is accepted only on a rising edge of its line, only in ready, and only if its mask bit is 0. A held line is accepted once. An accepted request sets its in-service bit.
- R11: `cpu_int` rises on the clock after an accepted request whose level outranks every other in-service level. It does not rise if a higher-priority level is in service.
- R12: Once high, `cpu_int` stays high until `int_ack` is sampled high or the in-service bit of the level that raised it is cleared.
- R13: If a request is accepted in the same cycle that a command clears the same in-service bit, the bit ends up set.
- R14: `cfg_err` stays set until reset or the next setup word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | Register port address bit |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_rd | input | 1 | Read strobe; a poll disarm takes effect at the edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from the address and state |
| irq_req | input | 8 | Request lines, one per level |
| int_ack | input | 1 | CPU acknowledge, drops `cpu_int` |
| cpu_int | output | 1 | Interrupt to the CPU |
| autovec | output | 1 | Autovector mode indicator, 1 |
| cpu_level | output | 3 | CPU interrupt level, 1 |
| vector | output | 8 | Vector number, 0x00 |
| cfg_err | output | 1 | Sticky flag for unsupported setup or commands |

## Verification
The interesting overlap is a rising request edge on a level in the same clock as a specific end-of-service command for that same level. The bench provokes it by changing `irq_req` and raising `reg_wr` with the command byte in one drive step. It then switches reads to the in-service register and expects the bit to be set, with `cpu_int` raised again. A second overlap, an accept arriving while a higher level is in service, is judged by `cpu_int` staying low while the new bit still appears in the in-service read.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int NLVL  = 8;
  localparam int LVL_W = $clog2(NLVL);

  typedef enum logic [1:0] {SQ_RESET, SQ_W2, SQ_W4, SQ_READY} seq_t;

  // command codes carried in bits 7:5 of an address-0 command byte
  localparam logic [2:0] CMD_NSP     = 3'b001;
  localparam logic [2:0] CMD_NSP_ROT = 3'b101;
  localparam logic [2:0] CMD_SP      = 3'b011;
  localparam logic [2:0] CMD_SP_ROT  = 3'b111;
  localparam logic [2:0] CMD_SETLOW  = 3'b110;
  localparam logic [2:0] CMD_NOP     = 3'b010;

  // Highest-ranked set bit of 'bits', searching lowest+1, lowest+2, ... mod NLVL.
  // Returns {found, level}.
  function automatic logic [LVL_W:0] top_level(input logic [NLVL-1:0] bits,
                                               input logic [LVL_W-1:0] lowest);
    logic [LVL_W:0]   r;
    logic [LVL_W-1:0] l;
    r = '0;
    for (int i = NLVL; i >= 1; i--) begin
      l = lowest + LVL_W'(i);
      if (bits[l]) r = {1'b1, l};
    end
    return r;
  endfunction

  function automatic logic [7:0] poll_code(input logic [NLVL-1:0] bits,
                                           input logic [LVL_W-1:0] lowest);
    logic [LVL_W:0] t;
    t = top_level(bits, lowest);
    return t[LVL_W] ? (8'h80 | 8'(t[LVL_W-1:0])) : 8'h00;
  endfunction
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [7:0]        wdata,
  input  logic [NLVL-1:0]   isr,
  output logic              ready,
  output logic              uninit,
  output logic [NLVL-1:0]   mask,
  output logic              rd_isr,
  output logic              poll_on,
  output logic [LVL_W-1:0]  lowest,
  output logic              err,
  output logic [NLVL-1:0]   eoi_clr
);
  seq_t st_q;
  logic single_q, need4_q;

  logic is_init, is_ocw3, is_cmd;
  logic [2:0] cmd;
  logic [LVL_W:0] nsp;

  assign is_init = wr && !addr && wdata[4];
  assign is_ocw3 = wr && !addr && !wdata[4] && wdata[3];
  assign is_cmd  = wr && !addr && !wdata[4] && !wdata[3];
  assign cmd     = wdata[7:5];
  assign nsp     = top_level(isr, lowest);
  assign ready   = (st_q == SQ_READY);
  assign uninit  = (st_q == SQ_RESET);

  always_comb begin
    eoi_clr = '0;
    if (is_cmd) begin
      case (cmd)
        CMD_NSP, CMD_NSP_ROT: if (nsp[LVL_W]) eoi_clr[nsp[LVL_W-1:0]] = 1'b1;
        CMD_SP, CMD_SP_ROT:   eoi_clr[wdata[LVL_W-1:0]] = 1'b1;
        default:              eoi_clr = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_RESET;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
      mask     <= '0;
      rd_isr   <= 1'b0;
      poll_on  <= 1'b0;
      lowest   <= LVL_W'(NLVL - 1);
      err      <= 1'b0;
    end else begin
      if (poll_on && rd && !addr && (isr == '0)) poll_on <= 1'b0;
      if (is_init) begin
        single_q <= wdata[1];
        need4_q  <= wdata[0];
        st_q     <= SQ_W2;
        rd_isr   <= 1'b0;
        poll_on  <= 1'b0;
        lowest   <= LVL_W'(NLVL - 1);
        err      <= 1'b0;
      end else if (wr && addr) begin
        case (st_q)
          SQ_RESET: err <= 1'b1;
          SQ_W2: begin
            if (single_q) st_q <= need4_q ? SQ_W4 : SQ_READY;
            else begin
              err  <= 1'b1;
              st_q <= SQ_RESET;
            end
          end
          SQ_W4: begin
            if (wdata[1] || wdata[3] || wdata[4]) err <= 1'b1;
            else st_q <= SQ_READY;
          end
          SQ_READY: mask <= wdata;
          default:  st_q <= SQ_RESET;
        endcase
      end else if (is_ocw3) begin
        if (wdata[6])      err     <= 1'b1;
        else if (wdata[2]) poll_on <= 1'b1;
        else if (wdata[1]) rd_isr  <= wdata[0];
      end else if (is_cmd) begin
        case (cmd)
          CMD_NSP_ROT:            if (nsp[LVL_W]) lowest <= nsp[LVL_W-1:0];
          CMD_SP_ROT, CMD_SETLOW: lowest <= wdata[LVL_W-1:0];
          3'b000, 3'b100:         err <= 1'b1;
          default:                err <= err;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic8_svc.sv
module pic8_svc
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   req,
  input  logic              ready,
  input  logic [NLVL-1:0]   mask,
  input  logic [LVL_W-1:0]  lowest,
  input  logic [NLVL-1:0]   clr,
  input  logic              ack,
  output logic [NLVL-1:0]   isr,
  output logic [NLVL-1:0]   acc,
  output logic              cpu_int
);
  logic [NLVL-1:0]  prev_q, rise, isr_nx;
  logic [LVL_W-1:0] pend_q;
  logic [LVL_W:0]   top;
  logic             raise;

  assign rise   = req & ~prev_q;
  assign acc    = ready ? (rise & ~mask) : '0;
  assign isr_nx = (isr & ~clr) | acc;   // a new accept wins over a clear
  assign top    = top_level(isr_nx, lowest);
  assign raise  = top[LVL_W] && acc[top[LVL_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      isr     <= '0;
      pend_q  <= '0;
      cpu_int <= 1'b0;
    end else begin
      prev_q <= req;
      isr    <= isr_nx;
      if (raise) begin
        cpu_int <= 1'b1;
        pend_q  <= top[LVL_W-1:0];
      end else if (ack || !isr_nx[pend_q]) begin
        cpu_int <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
#(
  parameter logic [2:0] CPU_LEVEL = 3'd1,
  parameter logic [7:0] VECTOR    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [7:0] irq_req,
  input  logic       int_ack,
  output logic       cpu_int,
  output logic       autovec,
  output logic [2:0] cpu_level,
  output logic [7:0] vector,
  output logic       cfg_err
);
  logic             seq_ready, seq_uninit, rd_isr, poll_on;
  logic [NLVL-1:0]  mask, isr, acc, eoi_clr;
  logic [LVL_W-1:0] lowest;

  pic8_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(wr_data), .isr(isr), .ready(seq_ready), .uninit(seq_uninit),
    .mask(mask), .rd_isr(rd_isr), .poll_on(poll_on), .lowest(lowest),
    .err(cfg_err), .eoi_clr(eoi_clr)
  );

  pic8_svc u_svc (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .ready(seq_ready), .mask(mask),
    .lowest(lowest), .clr(eoi_clr), .ack(int_ack), .isr(isr), .acc(acc),
    .cpu_int(cpu_int)
  );

  always_comb begin
    if (reg_addr)     rd_data = mask;
    else if (poll_on) rd_data = poll_code(isr, lowest);
    else if (rd_isr)  rd_data = isr;
    else              rd_data = irq_req;
  end

  assign autovec   = 1'b1;
  assign cpu_level = CPU_LEVEL;
  assign vector    = VECTOR;
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       reg_addr,
  input logic [7:0] wr_data,
  input logic       seq_ready,
  input logic       seq_uninit,
  input logic       poll_on,
  input logic [7:0] mask,
  input logic [7:0] isr,
  input logic [7:0] acc,
  input logic       cpu_int,
  input logic       cfg_err
);
  assert_accept_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != 8'h00) |-> (seq_ready && ((acc & mask) == 8'h00)));

  assert_no_isr_growth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_ready |=> ((isr & ~$past(isr)) == 8'h00));

  assert_err_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !(reg_wr && !reg_addr && wr_data[4])) |=> cfg_err);

  assert_refuse_uninit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_uninit && reg_wr && reg_addr) |=> (cfg_err && !seq_ready));

  assert_int_needs_service_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> (isr != 8'h00));

  assert_poll_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_on && reg_rd && !reg_addr && !reg_wr && (isr == 8'h00)) |=> !poll_on);

  assert_accept_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != 8'h00) |=> ((isr & $past(acc)) == $past(acc)));
endmodule

bind pic8_ctrl pic8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .wr_data(wr_data), .seq_ready(seq_ready),
  .seq_uninit(seq_uninit), .poll_on(poll_on), .mask(mask), .isr(isr),
  .acc(acc), .cpu_int(cpu_int), .cfg_err(cfg_err)
);

// File: tb/test_pic8_ctrl.sv
module test_pic8_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, int_ack = 1'b0;
  logic [7:0] wr_data = 8'h00, irq_req = 8'h00;
  logic [7:0] rd_data, vector;
  logic [2:0] cpu_level;
  logic       cpu_int, autovec, cfg_err;

  always #4 clk = ~clk;

  pic8_ctrl i_pic8_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req),
    .int_ack(int_ack), .cpu_int(cpu_int), .autovec(autovec),
    .cpu_level(cpu_level), .vector(vector), .cfg_err(cfg_err)
  );

  // sel 0: rd_data, 1: {cpu_int,cfg_err}, 2: {autovec,cpu_level,vector}
  typedef struct {int sel; logic [15:0] exp; string req;} item_t;
  item_t sbq[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sbq.pop_front();
      case (it.sel)
        0:       act = {8'h00, rd_data};
        1:       act = {14'h0, cpu_int, cfg_err};
        default: act = {4'h0, autovec, cpu_level, vector};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_it(int sel, logic [15:0] e, string r);
    sbq.push_back('{sel, e, r});
    tick(1);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_addr = a; wr_data = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic a, logic [7:0] e, string r);
    reg_addr = a; reg_rd = 1'b1;
    sbq.push_back('{0, {8'h00, e}, r});
    tick(1);
    reg_rd = 1'b0;
  endtask

  task automatic flags(logic i, logic e, string r);
    expect_it(1, {14'h0, i, e}, r);
  endtask

  task automatic irq(logic [7:0] v);
    irq_req = v;
    tick(1);
  endtask

  task automatic ack();
    int_ack = 1'b1;
    tick(1);
    int_ack = 1'b0;
  endtask

  task automatic setup_plain();
    wr(1'b0, 8'h12);
    wr(1'b0 ^ 1'b1, 8'h00);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    flags(0, 0, "R1 flags");
    expect_it(2, 16'h0900, "R1 autovector level vector");
    rd_chk(0, 8'h00, "R1 request lines");
    rd_chk(1, 8'h00, "R1 mask");
    // R10 ignored before ready
    irq(8'h04); irq(8'h00);
    flags(0, 0, "R10 not ready");
    // R3 refused write
    wr(1, 8'hFF);
    flags(0, 1, "R3 error");
    rd_chk(1, 8'h00, "R3 mask kept");
    // R2 / R14 setup word clears error
    wr(0, 8'h13);
    flags(0, 0, "R14 cleared by setup");
    // R5 word 4 checks
    wr(1, 8'h20);
    wr(1, 8'h02);
    flags(0, 1, "R5 word4 bit1");
    wr(1, 8'h10);
    wr(1, 8'h00);
    flags(0, 1, "R14 sticky");
    wr(1, 8'hF0);
    rd_chk(1, 8'hF0, "R5 mask load");
    // R4 single without word 4 -> ready
    wr(0, 8'h12);
    flags(0, 0, "R2 error cleared");
    wr(1, 8'h00);
    wr(1, 8'h08);
    rd_chk(1, 8'h08, "R4 ready after word2");
    // R4 cascade refused
    wr(0, 8'h10);
    wr(1, 8'h00);
    flags(0, 1, "R4 cascade error");
    wr(1, 8'h55);
    rd_chk(1, 8'h08, "R4 back to uninit");
    wr(0, 8'h12); wr(1, 8'h00);
    wr(1, 8'h80);
    // R6 select in-service; R10 earlier request ignored
    wr(0, 8'h0B);
    rd_chk(0, 8'h00, "R10 isr empty");
    irq(8'h80);
    flags(0, 0, "R10 masked");
    irq(8'h88);
    flags(1, 0, "R11 raise level3");
    rd_chk(0, 8'h08, "R10 accepted");
    ack();
    tick(3);
    flags(0, 0, "R12 ack drops");
    rd_chk(0, 8'h08, "R10 held once");
    irq(8'h8A);
    flags(1, 0, "R11 higher level1");
    rd_chk(0, 8'h0A, "R10 level1 set");
    ack();
    irq(8'hAA);
    flags(0, 0, "R11 lower level5 blocked");
    rd_chk(0, 8'h2A, "R11 level5 in service");
    // R9 poll
    wr(0, 8'h0C);
    rd_chk(0, 8'h81, "R9 poll");
    rd_chk(0, 8'h81, "R9 poll stays armed");
    wr(0, 8'h20);
    rd_chk(0, 8'h83, "R8 nonspecific");
    wr(0, 8'hC3);
    rd_chk(0, 8'h85, "R7 set lowest");
    wr(0, 8'hA0);
    rd_chk(0, 8'h83, "R8 rotate nonspecific");
    wr(0, 8'h63);
    rd_chk(0, 8'h00, "R9 empty poll");
    // R6 request source; lowest is 5 so level6 ranks first
    wr(0, 8'h0A);
    irq(8'h00);
    irq(8'h40);
    rd_chk(0, 8'h40, "R6 raw requests");
    flags(1, 0, "R11 level6 after rotate");
    wr(0, 8'hE6);
    flags(0, 0, "R12 cleared by command");
    wr(0, 8'h0B);
    rd_chk(0, 8'h00, "R7 rotate specific clear");
    // R7 codes
    wr(0, 8'h40);
    flags(0, 0, "R7 nop");
    wr(0, 8'h00);
    flags(0, 1, "R7 code000");
    setup_plain();
    wr(0, 8'h80);
    flags(0, 1, "R7 code100");
    setup_plain();
    wr(0, 8'h48);
    flags(0, 1, "R6 special mask");
    setup_plain();
    rd_chk(0, 8'h40, "R2 request source");
    // R13 accept and clear same cycle
    irq(8'h00);
    irq(8'h04);
    ack();
    irq(8'h00);
    reg_addr = 1'b0; wr_data = 8'h62; reg_wr = 1'b1; irq_req = 8'h04;
    tick(1);
    reg_wr = 1'b0;
    wr(0, 8'h0B);
    rd_chk(0, 8'h04, "R13 accept wins");
    flags(1, 0, "R13 raise");
    tick(2);
    done = 1;
    summary();
    $finish;
  end
endmodule